// File: doc/BRIEF.md
# Serial EEPROM Write-Path Slave

This block is the target side of a two-wire serial EEPROM, limited to write traffic. It sees the clock and data lines after they have been sampled into the system clock, and it pulls the data line low through an open-drain enable. A transaction opens with a Start and a select byte that carries a fixed device code, three chip-enable bits and a direction bit. Two address bytes follow, high byte first, and then one or more data bytes, which are collected in a page buffer.

Memory changes only if the master ends the transfer with a Stop placed right after the acknowledge of a data byte. The block then runs a timed internal programming cycle. During that cycle it keeps the data line released and takes no part in the bus. When the cycle ends, the buffered bytes land in a modelled byte array, and a pointer moves to the location after the last byte written. A write-lock input, seen high at any point between the Start and the end of the second address byte, blocks the whole transfer.

The array is visible through a combinational inspection port, for use by a later read path.

Top module: `eewr_slave_wr`

## Requirements
- R1: After a Start, a select byte with bits [7:4] equal to DEV_CODE (default 4'b1010), bits [3:1] equal to `chip_sel` and bit 0 equal to 0 (write) is acknowledged. `sda_pull` goes high only after a falling edge of `scl_s`.
- R2: A select byte that differs in the code or chip bits, or that has bit 0 set, is not acknowledged. No byte after it is acknowledged until the next Start, and memory is left unchanged.
- R3: Both address bytes are acknowledged. They form a 16-bit address, high byte first. The array is indexed by the low MEM_AW bits of that address.
- R4: If `wr_lock` is high in any cycle from the Start to the end of the second address byte, no data byte is acknowledged and memory is not modified.
- R5: A Stop that follows, as the next bus event, the acknowledge of at least one accepted data byte starts a programming cycle. A Stop in the middle of a byte, or one that comes right after the address bytes, starts none and drops the buffered bytes.
- R6: While a programming cycle runs, `sda_pull` stays low. Start conditions and select bytes get no response, and bus activity in that time writes nothing.
- R7: `wcyc_active` stays high for exactly WR_CYCLES clocks. Array contents are unchanged until the cycle ends.
- R8: Consecutive data bytes go to consecutive addresses. The low log2(PAGE_BYTES) address bits wrap inside the page while the upper bits stay fixed, so a later byte overwrites an earlier one at the same wrapped position. Page positions that received no byte keep their old values.
- R9: When a programming cycle completes, `next_addr` becomes the address after the last byte written, wrapped within the page. It changes at no other time.
- R10: A repeated Start at any point throws away a partly received write and begins select decoding again.
- R11: After reset, `sda_pull` and `wcyc_active` are low, `next_addr` is zero and every array byte reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_s | input | 1 | Bus clock, already sampled into clk |
| sda_s | input | 1 | Bus data line level, already sampled into clk |
| chip_sel | input | 3 | Chip-enable strap compared with select bits [3:1] |
| wr_lock | input | 1 | Write lock; high blocks the transaction |
| sda_pull | output | 1 | Open-drain enable; 1 pulls the data line low |
| wcyc_active | output | 1 | High during the internal programming cycle |
| next_addr | output | 16 | Internal address pointer after the last completed write |
| peek_addr | input | MEM_AW | Array inspection address |
| peek_data | output | 8 | Array byte at `peek_addr` |

## Verification
A wrong decode state becomes visible at the very next acknowledge slot, less than ten bus clocks later. A missing or extra acknowledge on a select, address or data byte shows up on the line the master samples. Errors in the commit condition or the lock latch show in `wcyc_active`, either rising when it should not or staying low, one clock after the Stop. A wrong page pointer or lost buffer byte is only seen once the programming cycle ends. At that point the inspection port gives the wrong byte at a wrapped position and `next_addr` is off. A wrong cycle length shows directly in how long `wcyc_active` stays high.

// File: rtl/eewr_pkg.sv
// Package: shared controller state type for the EEPROM write slave.
// Assumes nothing beyond IEEE 1800-2017 enums.
package eewr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_DATA,
        ST_PROG
    } eewr_state_e;

endpackage

// File: rtl/eewr_busdet.sv
// Bus condition detector: turns sampled clock/data levels into one-cycle
// pulses for clock edges, Start and Stop. Assumes inputs are already
// synchronised to clk and free of glitches.
module eewr_busdet (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic scl_q;
    logic sda_q;

    // Hold previous line levels (idle bus is high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/eewr_rxbyte.sv
// Byte receiver: shifts BITS data bits MSB first on clock rises, flags a
// complete byte, drives the acknowledge in the following slot when asked,
// and marks the bit slot that directly follows an acknowledge slot.
// Assumes ack_req is settled before the clock falls after the last bit.
module eewr_rxbyte #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            restart,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            sda_s,
    input  logic            ack_req,
    output logic [BITS-1:0] rx_byte,
    output logic            byte_done,
    output logic            sda_pull,
    output logic            after_ack
);

    localparam int CNT_W = $clog2(BITS + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(BITS);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BITS + 1);

    logic [CNT_W-1:0] bit_cnt;

    // Bit counting, shifting and acknowledge drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
            sda_pull  <= 1'b0;
            after_ack <= 1'b0;
        end else if (hold || restart) begin
            bit_cnt   <= '0;
            byte_done <= 1'b0;
            sda_pull  <= 1'b0;
            after_ack <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (scl_rise) begin
                if (bit_cnt < FULL) begin
                    rx_byte <= {rx_byte[BITS-2:0], sda_s};
                    bit_cnt <= bit_cnt + CNT_W'(1);
                    if (bit_cnt == LAST_BIT) begin
                        byte_done <= 1'b1;
                    end
                end else if (bit_cnt == FULL) begin
                    bit_cnt <= ACK_SLOT;
                end
            end else if (scl_fall) begin
                if (bit_cnt == FULL) begin
                    sda_pull  <= ack_req;
                    after_ack <= 1'b0;
                end else if (bit_cnt == ACK_SLOT) begin
                    sda_pull  <= 1'b0;
                    bit_cnt   <= '0;
                    after_ack <= 1'b1;
                end else begin
                    after_ack <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/eewr_pagebuf.sv
// Page buffer: one byte register and a written flag per page position.
// Assumes wr_idx is already wrapped to the page.
module eewr_pagebuf #(
    parameter int PAGE_BYTES = 64,
    parameter int PG_AW      = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr_en,
    input  logic [PG_AW-1:0]        wr_idx,
    input  logic [7:0]              wr_data,
    output logic [PAGE_BYTES*8-1:0] pg_data,
    output logic [PAGE_BYTES-1:0]   pg_vld
);

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        // Capture a byte into this slot, or forget it on clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pg_data[g*8 +: 8] <= '0;
                pg_vld[g]         <= 1'b0;
            end else if (clr) begin
                pg_vld[g] <= 1'b0;
            end else if (wr_en && (wr_idx == PG_AW'(g))) begin
                pg_data[g*8 +: 8] <= wr_data;
                pg_vld[g]         <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/eewr_array.sv
// Modelled byte array: on commit, copies every flagged page slot into the
// selected page in one clock. Combinational inspection read.
// Assumes MEM_AW > PG_AW.
module eewr_array #(
    parameter int MEM_AW     = 10,
    parameter int PAGE_BYTES = 64,
    parameter int PG_AW      = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  logic [MEM_AW-PG_AW-1:0] page_sel,
    input  logic [PAGE_BYTES*8-1:0] pg_data,
    input  logic [PAGE_BYTES-1:0]   pg_vld,
    input  logic [MEM_AW-1:0]       peek_addr,
    output logic [7:0]              peek_data
);

    localparam int DEPTH = 2 ** MEM_AW;

    logic [7:0] cells [DEPTH];

    // Clear on reset; commit flagged slots of the page buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (commit) begin
            for (int j = 0; j < PAGE_BYTES; j++) begin
                if (pg_vld[j]) begin
                    cells[{page_sel, PG_AW'(j)}] <= pg_data[j*8 +: 8];
                end
            end
        end
    end

    assign peek_data = cells[peek_addr];

endmodule

// File: rtl/eewr_slave_wr.sv
// EEPROM write slave top: decodes select and address bytes, gathers data
// into the page buffer, latches the write lock, and runs the timed
// programming cycle that commits the page.
// Assumes sampled, glitch-free bus lines; reads are handled elsewhere.
module eewr_slave_wr
    import eewr_pkg::*;
#(
    parameter logic [3:0] DEV_CODE   = 4'b1010,
    parameter int         MEM_AW     = 10,
    parameter int         PAGE_BYTES = 64,
    parameter int         WR_CYCLES  = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic [2:0]        chip_sel,
    input  logic              wr_lock,
    output logic              sda_pull,
    output logic              wcyc_active,
    output logic [15:0]       next_addr,
    input  logic [MEM_AW-1:0] peek_addr,
    output logic [7:0]        peek_data
);

    localparam int ADDR_W = 16;
    localparam int PG_AW  = $clog2(PAGE_BYTES);
    localparam int TMR_W  = $clog2(WR_CYCLES + 1);

    eewr_state_e state;
    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic [7:0] rx_byte;
    logic byte_done, after_ack;
    logic ack_q, inhibit, have_data;
    logic [ADDR_W-1:0] addr_q;
    logic [TMR_W-1:0] tmr;
    logic hold, commit, commit_go, pb_clr, pb_wr;
    logic [PAGE_BYTES*8-1:0] pg_data;
    logic [PAGE_BYTES-1:0] pg_vld;
    logic sel_match, lock_window;

    assign hold        = (state == ST_PROG);
    assign commit      = hold && (tmr == '0);
    assign wcyc_active = hold;
    assign sel_match   = (rx_byte[7:1] == {DEV_CODE, chip_sel}) && !rx_byte[0];
    assign lock_window = (state == ST_DEVSEL) || (state == ST_ADDR_HI) ||
                         (state == ST_ADDR_LO);
    assign commit_go   = stop_ev && (state == ST_DATA) && after_ack &&
                         have_data && !inhibit;
    assign pb_wr       = byte_done && (state == ST_DATA) && !inhibit;
    assign pb_clr      = commit || (!hold && start_ev) ||
                         (!hold && stop_ev && !commit_go);

    eewr_busdet u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    eewr_rxbyte #(.BITS(8)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .restart   (start_ev),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .ack_req   (ack_q),
        .rx_byte   (rx_byte),
        .byte_done (byte_done),
        .sda_pull  (sda_pull),
        .after_ack (after_ack)
    );

    eewr_pagebuf #(.PAGE_BYTES(PAGE_BYTES), .PG_AW(PG_AW)) u_pb (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pb_clr),
        .wr_en   (pb_wr),
        .wr_idx  (addr_q[PG_AW-1:0]),
        .wr_data (rx_byte),
        .pg_data (pg_data),
        .pg_vld  (pg_vld)
    );

    eewr_array #(.MEM_AW(MEM_AW), .PAGE_BYTES(PAGE_BYTES), .PG_AW(PG_AW)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .page_sel  (addr_q[MEM_AW-1:PG_AW]),
        .pg_data   (pg_data),
        .pg_vld    (pg_vld),
        .peek_addr (peek_addr),
        .peek_data (peek_data)
    );

    // Transaction sequencing, lock latch, address pointer and cycle timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ack_q     <= 1'b0;
            inhibit   <= 1'b0;
            have_data <= 1'b0;
            addr_q    <= '0;
            tmr       <= '0;
            next_addr <= '0;
        end else if (state == ST_PROG) begin
            if (tmr == '0) begin
                state     <= ST_IDLE;
                next_addr <= addr_q;
            end else begin
                tmr <= tmr - TMR_W'(1);
            end
        end else if (start_ev) begin
            state     <= ST_DEVSEL;
            inhibit   <= wr_lock;
            ack_q     <= 1'b0;
            have_data <= 1'b0;
        end else if (stop_ev) begin
            ack_q <= 1'b0;
            if (commit_go) begin
                state <= ST_PROG;
                tmr   <= TMR_W'(WR_CYCLES - 1);
            end else begin
                state <= ST_IDLE;
            end
        end else begin
            if (wr_lock && lock_window) begin
                inhibit <= 1'b1;
            end
            if (byte_done) begin
                unique case (state)
                    ST_DEVSEL: begin
                        ack_q <= sel_match;
                        state <= sel_match ? ST_ADDR_HI : ST_IDLE;
                    end
                    ST_ADDR_HI: begin
                        addr_q[ADDR_W-1:8] <= rx_byte;
                        ack_q              <= 1'b1;
                        state              <= ST_ADDR_LO;
                    end
                    ST_ADDR_LO: begin
                        addr_q[7:0] <= rx_byte;
                        ack_q       <= 1'b1;
                        state       <= ST_DATA;
                    end
                    ST_DATA: begin
                        ack_q <= !inhibit;
                        if (!inhibit) begin
                            addr_q[PG_AW-1:0] <= addr_q[PG_AW-1:0] + PG_AW'(1);
                            have_data         <= 1'b1;
                        end
                    end
                    default: begin
                        ack_q <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/eewr_slave_wr_chk.sv
// Checker for the EEPROM write slave: timing and protocol properties,
// attached to every instance of the top by bind.
module eewr_slave_wr_chk #(
    parameter int WR_CYCLES = 1000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_s,
    input logic        sda_pull,
    input logic        wcyc_active,
    input logic [15:0] next_addr,
    input logic        inhibit,
    input logic        start_ev,
    input logic        after_ack
);

    logic [31:0] prog_cnt;

    // Length of the current programming window.
    always_ff @(posedge clk) begin
        if (!rst_n || !wcyc_active) begin
            prog_cnt <= '0;
        end else begin
            prog_cnt <= prog_cnt + 32'd1;
        end
    end

    AST_PULL_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(!scl_s)); // R1
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !start_ev) |=> inhibit); // R4
    AST_PROG_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wcyc_active) |-> $past(after_ack)); // R5
    AST_QUIET_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        wcyc_active |-> !sda_pull); // R6
    AST_PROG_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wcyc_active) |-> (prog_cnt == 32'(WR_CYCLES))); // R7
    AST_PTR_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(wcyc_active) |-> $stable(next_addr)); // R9

endmodule

bind eewr_slave_wr eewr_slave_wr_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .sda_pull    (sda_pull),
    .wcyc_active (wcyc_active),
    .next_addr   (next_addr),
    .inhibit     (inhibit),
    .start_ev    (start_ev),
    .after_ack   (after_ack)
);

// File: tb/sim_eewr_slave_wr.sv
module sim_eewr_slave_wr;

    localparam int CLK_PERIOD = 10;
    localparam int PAGE = 16;
    localparam int WRC  = 300;
    localparam int MAW  = 10;
    localparam int Q    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] ce = 3'b101;
    logic lock = 1'b0;
    logic [MAW-1:0] peek_addr = '0;
    logic sda_pull, wcyc;
    logic [15:0] next_addr;
    logic [7:0] peek_data;
    logic sda_line;

    int total = 0;
    int bad = 0;
    logic [7:0] ref_mem [1024];
    logic [15:0] ref_next = '0;
    logic [7:0] wd [64];

    assign sda_line = sda_m & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    eewr_slave_wr #(
        .DEV_CODE(4'b1010), .MEM_AW(MAW), .PAGE_BYTES(PAGE), .WR_CYCLES(WRC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_m), .sda_s(sda_line),
        .chip_sel(ce), .wr_lock(lock), .sda_pull(sda_pull),
        .wcyc_active(wcyc), .next_addr(next_addr),
        .peek_addr(peek_addr), .peek_data(peek_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        scl_m = 1'b0; half();
        sda_m = 1'b1; half();
        scl_m = 1'b1; half();
        sda_m = 1'b0; half();
        scl_m = 1'b0; half();
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; half();
        sda_m = 1'b0; half();
        scl_m = 1'b1; half();
        sda_m = 1'b1;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = b[7-i]; half();
            scl_m = 1'b1; half();
            scl_m = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] b, input bit exp_ack, input string tag);
        bit acked;
        send_bits(b, 8);
        sda_m = 1'b1; half();
        scl_m = 1'b1; half();
        acked = !sda_line;
        scl_m = 1'b0; half();
        chk(acked == exp_ack, tag, int'(acked), int'(exp_ack));
    endtask

    function automatic logic [9:0] widx(input logic [15:0] a, input int k);
        logic [3:0] p;
        p = a[3:0] + 4'(k);
        return {a[9:4], p};
    endfunction

    function automatic logic [15:0] after_last(input logic [15:0] a, input int len);
        logic [3:0] p;
        p = a[3:0] + 4'(len);
        return {a[15:4], p};
    endfunction

    task automatic prog_wait(input bit exp_w, input bit chk_len,
                             input logic [9:0] pidx, input logic [7:0] pold);
        int n;
        bit pulled;
        n = 0;
        pulled = 1'b0;
        peek_addr = pidx;
        @(negedge clk);
        while (wcyc && n < WRC + 50) begin
            n++;
            if (sda_pull) pulled = 1'b1;
            if (n == WRC/2 && exp_w) chk(peek_data == pold, "R7 unchanged mid-cycle", peek_data, pold);
            @(negedge clk);
        end
        if (exp_w) begin
            if (chk_len) chk(n == WRC, "R7 cycle length", n, WRC);
        end else begin
            chk(n == 0, "R5 no cycle", n, 0);
        end
        chk(!pulled, "R6 released in cycle", int'(pulled), 0);
    endtask

    task automatic check_page(input logic [15:0] a, input string tag);
        for (int q = 0; q < PAGE; q++) begin
            peek_addr = {a[9:4], 4'(q)};
            @(negedge clk);
            chk(peek_data == ref_mem[{a[9:4], 4'(q)}], tag, peek_data, ref_mem[{a[9:4], 4'(q)}]);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input int len, input int lock_at,
                            input bit mid_stop, input bit intrude);
        bit wr_ok;
        logic [7:0] pold;
        wr_ok = (lock_at < 0) && !mid_stop && (len > 0);
        for (int k = 0; k < len; k++) wd[k] = 8'($urandom);
        lock = (lock_at == 0);
        bus_start();
        xfer({4'b1010, ce, 1'b0}, 1'b1, "R1 select ack");
        lock = (lock_at == 1);
        xfer(a[15:8], 1'b1, "R3 addr hi ack");
        lock = (lock_at == 2);
        xfer(a[7:0], 1'b1, "R3 addr lo ack");
        lock = 1'b0;
        for (int k = 0; k < len; k++) xfer(wd[k], lock_at < 0, "R4 data ack");
        if (mid_stop) send_bits(8'($urandom), 3);
        bus_stop();
        pold = ref_mem[widx(a, 0)];
        if (intrude) begin
            half();
            chk(wcyc == 1'b1, "R6 cycle running", int'(wcyc), 1);
            bus_start();
            xfer({4'b1010, ce, 1'b0}, 1'b0, "R6 select ignored");
            xfer(8'h00, 1'b0, "R6 byte ignored");
            xfer(8'h00, 1'b0, "R6 byte ignored");
            xfer(8'h99, 1'b0, "R6 byte ignored");
            bus_stop();
        end
        prog_wait(wr_ok, !intrude, widx(a, 0), pold);
        if (wr_ok) begin
            for (int k = 0; k < len; k++) ref_mem[widx(a, k)] = wd[k];
            ref_next = after_last(a, len);
        end
        check_page(a, lock_at >= 0 ? "R4 page" : (mid_stop ? "R5 page" : "R8 page"));
        chk(next_addr == ref_next, "R9 next_addr", next_addr, ref_next);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R7 act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed_sink;
        logic [15:0] ra;
        int rl, rr, la;
        bit mid;
        for (int i = 0; i < 1024; i++) ref_mem[i] = '0;
        seed_sink = int'($urandom(32'h1F2E3D4C));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk(sda_pull == 1'b0, "R11 sda_pull", int'(sda_pull), 0);
        chk(wcyc == 1'b0, "R11 wcyc_active", int'(wcyc), 0);
        chk(next_addr == 16'h0, "R11 next_addr", next_addr, 0);
        check_page(16'h0120, "R11 array zero");

        // R1/R3/R7 single byte write
        do_write(16'h0123, 1, -1, 1'b0, 1'b0);

        // R2 wrong chip bits, wrong code, read direction
        bus_start();
        xfer({4'b1010, ~ce, 1'b0}, 1'b0, "R2 chip mismatch");
        xfer(8'h01, 1'b0, "R2 later byte");
        xfer(8'h23, 1'b0, "R2 later byte");
        xfer(8'h77, 1'b0, "R2 later byte");
        bus_stop();
        prog_wait(1'b0, 1'b0, 10'h123, 8'h0);
        check_page(16'h0123, "R2 page");
        bus_start();
        xfer({4'b0110, ce, 1'b0}, 1'b0, "R2 code mismatch");
        bus_stop();
        prog_wait(1'b0, 1'b0, 10'h0, 8'h0);
        bus_start();
        xfer({4'b1010, ce, 1'b1}, 1'b0, "R2 read direction");
        bus_stop();
        prog_wait(1'b0, 1'b0, 10'h0, 8'h0);
        chk(next_addr == ref_next, "R2 next_addr", next_addr, ref_next);

        // R8 wrap and overwrite
        do_write(16'h0F3E, 5, -1, 1'b0, 1'b0);
        do_write(16'h0205, 20, -1, 1'b0, 1'b0);

        // R4 lock in each phase
        do_write(16'h0300, 3, 0, 1'b0, 1'b0);
        do_write(16'h0310, 3, 2, 1'b0, 1'b0);

        // R5 mid-byte stop and stop after address only
        do_write(16'h0320, 4, -1, 1'b1, 1'b0);
        do_write(16'h0330, 0, -1, 1'b0, 1'b0);

        // R6 bus ignored during the cycle
        do_write(16'h0340, 2, -1, 1'b0, 1'b1);

        // R10 repeated start drops partial write
        bus_start();
        xfer({4'b1010, ce, 1'b0}, 1'b1, "R10 select");
        xfer(8'h00, 1'b1, "R10 addr");
        xfer(8'h40, 1'b1, "R10 addr");
        xfer(8'hAA, 1'b1, "R10 data");
        xfer(8'hBB, 1'b1, "R10 data");
        bus_start();
        xfer({4'b1010, ce, 1'b0}, 1'b1, "R10 reselect");
        xfer(8'h00, 1'b1, "R10 addr");
        xfer(8'h50, 1'b1, "R10 addr");
        xfer(8'hCC, 1'b1, "R10 data");
        bus_stop();
        prog_wait(1'b1, 1'b1, 10'h050, ref_mem[10'h050]);
        ref_mem[10'h050] = 8'hCC;
        ref_next = 16'h0051;
        check_page(16'h0040, "R10 dropped page");
        check_page(16'h0050, "R10 second page");
        chk(next_addr == ref_next, "R10 next_addr", next_addr, ref_next);

        // Random mix
        for (int t = 0; t < 24; t++) begin
            ra = 16'($urandom);
            rl = int'($urandom_range(0, 22));
            rr = int'($urandom_range(0, 7));
            la = (rr < 3) ? rr : -1;
            mid = ($urandom_range(0, 4) == 0);
            do_write(ra, rl, la, mid, 1'b0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule